// File: doc/BRIEF.md
# Clock Fanout Mode and Bank Controller

This block is the digital control core of an eight-output clock fanout buffer. Two banks of four outputs, bank A and bank B, are modelled as data bits plus output-enable bits rather than tristate pins. A two-bit select input picks one of four operating modes. The mode decides which banks drive, whether the outputs carry the PLL clock or the raw reference (bypass), and whether the PLL is enabled or shut down.

A reference-activity monitor runs on a free-running sampling clock. It synchronises the reference input, detects its rising edges and counts sampling cycles between them. When no rising edge arrives within a parameterised timeout, the block enters power-down. In power-down every output is disabled and the PLL is shut down, whatever the select code. The first rising edge after the loss ends power-down. Banks fed from the PLL then wait for the lock input before they drive. Banks in bypass drive at once.

An elaboration parameter selects a variant that inverts the bank outputs in bypass. The PLL itself, its feedback loop, frequency multiplication and analog behaviour are supplied from outside: the PLL clock and the lock flag are inputs.

Top module: `cbuf_ctrl`

## Requirements
- R1: All outputs of a bank share one enable: the four enable bits of a bank are always all 1 or all 0. A disabled output carries data 0.
- R2: Select code 00 disables both banks and drives PLL enable low.
- R3: Select code 01 drives bank A from the PLL clock, keeps bank B disabled and drives PLL enable high.
- R4: Select code 10 is bypass: both banks carry the reference input, PLL enable is low, and the banks are enabled without waiting for lock.
- R5: Select code 11 drives both banks from the PLL clock, with PLL enable high.
- R6: When TIMEOUT consecutive sampling cycles pass with no detected reference rising edge, PLL enable and both bank enables go low, whatever the select code.
- R7: The first detected reference rising edge after a loss ends power-down. PLL enable and bypass banks follow the select code again from the next sampling cycle.
- R8: A bank sourced from the PLL is enabled only in the cycle after the lock input was high while PLL enable was already high. It drops again when lock falls.
- R9: With INV_BYPASS = 1, bypass outputs carry the inverted reference. In all other modes the data is the same as with INV_BYPASS = 0.
- R10: During reset the select code is taken as 11 and all enables are low. A select value sampled at one sampling edge is reflected on the enables and data at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Mode select code |
| ref_in | input | 1 | Reference clock, treated as an asynchronous data input |
| pll_clk | input | 1 | Clock from the external PLL |
| pll_locked | input | 1 | Lock flag from the external PLL |
| pll_en | output | 1 | Registered PLL enable (0 = shut down) |
| bank_a_clk | output | LANES | Bank A clock data |
| bank_a_oe | output | LANES | Bank A output enables |
| bank_b_clk | output | LANES | Bank B clock data |
| bank_b_oe | output | LANES | Bank B output enables |
| stat_en_a | output | 1 | Registered bank A enable status |
| stat_en_b | output | 1 | Registered bank B enable status |

## Verification
The hardest state to reach is leaving power-down. This needs the reference to be held still for the whole timeout and then restarted. The PLL-sourced banks must then stay off until the stand-in lock flag rises again. The stimulus stops the reference toggler for longer than the timeout in both a PLL mode and bypass. It then restarts it and lets the behavioural PLL stand-in drop lock while PLL enable is low and raise lock a fixed delay after it returns. The reference model and the design are compared every cycle through that whole sequence.

// File: rtl/cbuf_pkg.sv
`timescale 1ns/1ps
package cbuf_pkg;

   typedef enum logic [1:0] {
      SEL_OFF    = 2'b00,
      SEL_A_ONLY = 2'b01,
      SEL_BYPASS = 2'b10,
      SEL_ALL    = 2'b11
   } sel_e;

   typedef struct packed {
      logic a_on;
      logic b_on;
      logic pll_on;
      logic bypass;
   } mode_t;

   function automatic mode_t decode_sel(input logic [1:0] code);
      mode_t m;
      m = '0;
      case (code)
         SEL_OFF:    m = '{a_on: 1'b0, b_on: 1'b0, pll_on: 1'b0, bypass: 1'b0};
         SEL_A_ONLY: m = '{a_on: 1'b1, b_on: 1'b0, pll_on: 1'b1, bypass: 1'b0};
         SEL_BYPASS: m = '{a_on: 1'b1, b_on: 1'b1, pll_on: 1'b0, bypass: 1'b1};
         default:    m = '{a_on: 1'b1, b_on: 1'b1, pll_on: 1'b1, bypass: 1'b0};
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cbuf_refmon.sv
`timescale 1ns/1ps
module cbuf_refmon #(
   parameter int TIMEOUT = 64
) (
   input  logic clk_smp,
   input  logic rst_n,
   input  logic ref_in,
   output logic ref_lost
);
   localparam int CW = $clog2(TIMEOUT + 1);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic [2:0]    sync_q;
   logic          rise;
   logic [CW-1:0] idle_q;

   assign rise = sync_q[1] & ~sync_q[2];

   always_ff @(posedge clk_smp) begin
      if (!rst_n) begin
         sync_q   <= '0;
         idle_q   <= '0;
         ref_lost <= 1'b0;
      end else begin
         sync_q <= {sync_q[1:0], ref_in};
         if (rise) begin
            idle_q   <= '0;
            ref_lost <= 1'b0;
         end else if (idle_q == LAST) begin
            ref_lost <= 1'b1;
         end else begin
            idle_q <= idle_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cbuf_mode.sv
`timescale 1ns/1ps
module cbuf_mode
   import cbuf_pkg::*;
(
   input  logic       clk_smp,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       ref_lost,
   input  logic       pll_locked,
   output logic [1:0] sel_q,
   output logic       pll_en_q,
   output logic       byp_q,
   output logic       en_a_q,
   output logic       en_b_q
);
   mode_t m;
   logic  pll_ready;

   assign m         = decode_sel(sel_q);
   assign pll_ready = pll_en_q & pll_locked;

   always_ff @(posedge clk_smp) begin
      if (!rst_n) begin
         sel_q    <= SEL_ALL;
         pll_en_q <= 1'b0;
         byp_q    <= 1'b0;
         en_a_q   <= 1'b0;
         en_b_q   <= 1'b0;
      end else begin
         sel_q    <= sel;
         pll_en_q <= ~ref_lost & m.pll_on;
         byp_q    <= ~ref_lost & m.bypass;
         en_a_q   <= ~ref_lost & m.a_on & (m.bypass | pll_ready);
         en_b_q   <= ~ref_lost & m.b_on & (m.bypass | pll_ready);
      end
   end
endmodule

// File: rtl/cbuf_bank.sv
`timescale 1ns/1ps
module cbuf_bank #(
   parameter int LANES      = 4,
   parameter bit INV_BYPASS = 1'b0
) (
   input  logic             en,
   input  logic             byp,
   input  logic             ref_in,
   input  logic             pll_clk,
   output logic [LANES-1:0] dout,
   output logic [LANES-1:0] oe
);
   logic byp_val;
   logic src;

   if (INV_BYPASS) begin : g_inv
      assign byp_val = ~ref_in;
   end else begin : g_true
      assign byp_val = ref_in;
   end

   assign src = byp ? byp_val : pll_clk;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[i] = en & src;
      assign oe[i]   = en;
   end
endmodule

// File: rtl/cbuf_ctrl.sv
`timescale 1ns/1ps
module cbuf_ctrl #(
   parameter int LANES      = 4,
   parameter int TIMEOUT    = 64,
   parameter bit INV_BYPASS = 1'b0
) (
   input  logic             clk_smp,
   input  logic             rst_n,
   input  logic [1:0]       sel,
   input  logic             ref_in,
   input  logic             pll_clk,
   input  logic             pll_locked,
   output logic             pll_en,
   output logic [LANES-1:0] bank_a_clk,
   output logic [LANES-1:0] bank_a_oe,
   output logic [LANES-1:0] bank_b_clk,
   output logic [LANES-1:0] bank_b_oe,
   output logic             stat_en_a,
   output logic             stat_en_b
);
   localparam int NBANK = 2;

   if (LANES < 1) begin : g_bad_lanes
      $error("cbuf_ctrl: LANES must be at least 1");
   end
   if (TIMEOUT < 4) begin : g_bad_tmo
      $error("cbuf_ctrl: TIMEOUT must be at least 4");
   end

   logic                        ref_lost;
   logic [1:0]                  sel_q;
   logic                        byp_q;
   logic [NBANK-1:0]            en_vec;
   logic [NBANK-1:0][LANES-1:0] dout_all;
   logic [NBANK-1:0][LANES-1:0] oe_all;

   cbuf_refmon #(.TIMEOUT(TIMEOUT)) i_refmon (
      .clk_smp  (clk_smp),
      .rst_n    (rst_n),
      .ref_in   (ref_in),
      .ref_lost (ref_lost)
   );

   cbuf_mode i_mode (
      .clk_smp    (clk_smp),
      .rst_n      (rst_n),
      .sel        (sel),
      .ref_lost   (ref_lost),
      .pll_locked (pll_locked),
      .sel_q      (sel_q),
      .pll_en_q   (pll_en),
      .byp_q      (byp_q),
      .en_a_q     (stat_en_a),
      .en_b_q     (stat_en_b)
   );

   assign en_vec = {stat_en_b, stat_en_a};

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      cbuf_bank #(.LANES(LANES), .INV_BYPASS(INV_BYPASS)) i_bank (
         .en      (en_vec[b]),
         .byp     (byp_q),
         .ref_in  (ref_in),
         .pll_clk (pll_clk),
         .dout    (dout_all[b]),
         .oe      (oe_all[b])
      );
   end

   assign bank_a_clk = dout_all[0];
   assign bank_a_oe  = oe_all[0];
   assign bank_b_clk = dout_all[1];
   assign bank_b_oe  = oe_all[1];
endmodule

// File: rtl/cbuf_ctrl_chk.sv
`timescale 1ns/1ps
module cbuf_ctrl_chk #(
   parameter int LANES = 4
) (
   input logic             clk_smp,
   input logic             rst_n,
   input logic             ref_lost,
   input logic [1:0]       sel_q,
   input logic             byp_q,
   input logic             pll_locked,
   input logic             pll_en,
   input logic             stat_en_a,
   input logic             stat_en_b,
   input logic [LANES-1:0] bank_a_clk,
   input logic [LANES-1:0] bank_a_oe,
   input logic [LANES-1:0] bank_b_clk,
   input logic [LANES-1:0] bank_b_oe
);
   a_r1_a_off_low: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !stat_en_a |-> (bank_a_clk == '0 && bank_a_oe == '0));
   a_r1_b_off_low: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !stat_en_b |-> (bank_b_clk == '0 && bank_b_oe == '0));
   a_r2_off_code: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (sel_q == 2'b00) |=> (!stat_en_a && !stat_en_b && !pll_en));
   a_r3_b_idle: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (sel_q == 2'b01) |=> !stat_en_b);
   a_r4_bypass_pll_off: assert property (@(posedge clk_smp) disable iff (!rst_n)
      byp_q |-> !pll_en);
   a_r6_powerdown: assert property (@(posedge clk_smp) disable iff (!rst_n)
      ref_lost |=> (!stat_en_a && !stat_en_b && !pll_en));
   a_r8_lock_gate: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (stat_en_a && !byp_q) |-> (pll_en && $past(pll_locked)));
endmodule

bind cbuf_ctrl cbuf_ctrl_chk #(.LANES(LANES)) i_chk (
   .clk_smp    (clk_smp),
   .rst_n      (rst_n),
   .ref_lost   (ref_lost),
   .sel_q      (sel_q),
   .byp_q      (byp_q),
   .pll_locked (pll_locked),
   .pll_en     (pll_en),
   .stat_en_a  (stat_en_a),
   .stat_en_b  (stat_en_b),
   .bank_a_clk (bank_a_clk),
   .bank_a_oe  (bank_a_oe),
   .bank_b_clk (bank_b_clk),
   .bank_b_oe  (bank_b_oe)
);

// File: tb/test_cbuf_ctrl.sv
`timescale 1ns/1ps
module test_cbuf_ctrl;
   localparam int L    = 4;
   localparam int TMO  = 64;
   localparam int LDLY = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] sel = 2'b11;
   logic ref_in = 1'b0;
   logic pll_clk = 1'b0;
   logic pll_locked = 1'b0;

   logic pll_en, en_a, en_b, pll_en_i, en_a_i, en_b_i;
   logic [L-1:0] a_clk, a_oe, b_clk, b_oe, a_clk_i, a_oe_i, b_clk_i, b_oe_i;

   always #4 clk = ~clk;

   cbuf_ctrl #(.LANES(L), .TIMEOUT(TMO), .INV_BYPASS(1'b0)) i_cbuf_ctrl (
      .clk_smp(clk), .rst_n(rst_n), .sel(sel), .ref_in(ref_in), .pll_clk(pll_clk),
      .pll_locked(pll_locked), .pll_en(pll_en), .bank_a_clk(a_clk), .bank_a_oe(a_oe),
      .bank_b_clk(b_clk), .bank_b_oe(b_oe), .stat_en_a(en_a), .stat_en_b(en_b));

   cbuf_ctrl #(.LANES(L), .TIMEOUT(TMO), .INV_BYPASS(1'b1)) i_cbuf_ctrl_inv (
      .clk_smp(clk), .rst_n(rst_n), .sel(sel), .ref_in(ref_in), .pll_clk(pll_clk),
      .pll_locked(pll_locked), .pll_en(pll_en_i), .bank_a_clk(a_clk_i), .bank_a_oe(a_oe_i),
      .bank_b_clk(b_clk_i), .bank_b_oe(b_oe_i), .stat_en_a(en_a_i), .stat_en_b(en_b_i));

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R10";
   bit ref_on = 1'b1;
   int ref_div = 0;
   int lk_cnt = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // stimulus sources: reference toggler, PLL clock, behavioural PLL lock
   always @(negedge clk) begin
      pll_clk = ~pll_clk;
      if (ref_on) begin
         ref_div++;
         if (ref_div == 2) begin
            ref_in  = ~ref_in;
            ref_div = 0;
         end
      end
      if (!pll_en) begin
         lk_cnt     = 0;
         pll_locked = 1'b0;
      end else if (lk_cnt < LDLY) begin
         lk_cnt++;
      end else begin
         pll_locked = 1'b1;
      end
   end

   // behavioural reference model
   bit m_s1, m_s2, m_s3, m_lost, m_pll, m_byp, m_ea, m_eb;
   int m_idle;
   bit [1:0] m_sel;

   always @(posedge clk) begin
      bit n_lost, a_want, b_want, bypass_mode, pll_mode, ready;
      int n_idle;
      if (!rst_n) begin
         {m_s1, m_s2, m_s3, m_lost, m_pll, m_byp, m_ea, m_eb} = '0;
         m_idle = 0;
         m_sel  = 2'b11;
      end else begin
         n_lost = m_lost;
         n_idle = m_idle;
         if (m_s2 && !m_s3) begin
            n_lost = 1'b0;
            n_idle = 0;
         end else if (m_idle == TMO - 1) begin
            n_lost = 1'b1;
         end else begin
            n_idle = m_idle + 1;
         end
         bypass_mode = (m_sel == 2'b10);
         pll_mode    = (m_sel == 2'b01) || (m_sel == 2'b11);
         a_want      = (m_sel != 2'b00);
         b_want      = (m_sel == 2'b10) || (m_sel == 2'b11);
         ready       = m_pll && pll_locked;
         m_pll  = !m_lost && pll_mode;
         m_byp  = !m_lost && bypass_mode;
         m_ea   = !m_lost && a_want && (bypass_mode || ready);
         m_eb   = !m_lost && b_want && (bypass_mode || ready);
         m_lost = n_lost;
         m_idle = n_idle;
         m_sel  = sel;
         m_s3   = m_s2;
         m_s2   = m_s1;
         m_s1   = ref_in;
      end
   end

   // compare every cycle, away from the clock edges
   always @(posedge clk) begin
      logic src, src_i;
      logic [L-1:0] xa, xb, xa_i, xb_i;
      #2;
      src   = m_byp ? ref_in : pll_clk;
      src_i = m_byp ? ~ref_in : pll_clk;
      xa    = m_ea ? {L{src}} : '0;
      xb    = m_eb ? {L{src}} : '0;
      xa_i  = m_ea ? {L{src_i}} : '0;
      xb_i  = m_eb ? {L{src_i}} : '0;
      chk({pll_en, en_a, en_b} === {m_pll, m_ea, m_eb}, tag, "pll_en/en_a/en_b",
          32'({pll_en, en_a, en_b}), 32'({m_pll, m_ea, m_eb}));
      chk({a_oe, b_oe} === {{L{m_ea}}, {L{m_eb}}}, "R1", "bank enables",
          32'({a_oe, b_oe}), 32'({{L{m_ea}}, {L{m_eb}}}));
      chk({a_clk, b_clk} === {xa, xb}, tag, "bank data",
          32'({a_clk, b_clk}), 32'({xa, xb}));
      chk({a_clk_i, b_clk_i} === {xa_i, xb_i}, "R9", "inverted-variant data",
          32'({a_clk_i, b_clk_i}), 32'({xa_i, xb_i}));
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      run(4);
      // R10: reset state
      @(posedge clk); #3;
      chk({pll_en, en_a, en_b, a_oe, b_oe} === '0, "R10", "reset outputs",
          32'({pll_en, en_a, en_b, a_oe, b_oe}), 32'h0);
      @(negedge clk); rst_n = 1'b1;
      tag = "R5";  sel = 2'b11; run(60);
      tag = "R3";  sel = 2'b01; run(40);
      tag = "R4";  sel = 2'b10; run(40);
      // R4: bypass enables without lock
      chk(en_a && en_b && !pll_en && !pll_locked, "R4", "bypass without lock",
          32'({en_a, en_b, pll_en, pll_locked}), 32'b1100);
      tag = "R2";  sel = 2'b00; run(30);
      tag = "R5";  sel = 2'b11; run(30);
      tag = "R6";  ref_on = 1'b0; run(100);
      chk(!pll_en && !en_a && !en_b, "R6", "power-down after timeout",
          32'({pll_en, en_a, en_b}), 32'h0);
      tag = "R7";  ref_on = 1'b1; run(8);
      tag = "R8";  run(40);
      chk(en_a && en_b && pll_en, "R8", "relocked banks",
          32'({pll_en, en_a, en_b}), 32'b111);
      tag = "R6";  sel = 2'b10; ref_on = 1'b0; run(100);
      tag = "R7";  ref_on = 1'b1; run(20);
      tag = "R10";
      for (int i = 0; i < 24; i++) begin
         sel = 2'(i % 4);
         run(1 + (i % 3));
      end
      tag = "R3";  sel = 2'b01; run(30);
      @(posedge clk); #3;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule